// File: doc/BRIEF.md
# Single-Transaction Snoop Broadcast Coordinator

This block coordinates ownership of one shared cache line among a group of line controllers. Any controller may present an initial request: a plain read or a read that claims ownership. Only one such request is open in the whole system at a time. A rotating-priority arbiter picks one requester while the block is idle. The block stores the opcode and the requester's index, and then sends a snoop to every other controller: a share snoop for a read and an invalidate snoop for an ownership request.

The snooped controllers send their answers directly to the requester, so those answers never pass through this block. Once the requester has collected its answers, it sends a completion message naming itself. That message closes the transaction, and the block can take a new request in the very next cycle. A completion message that names any other controller is consumed but does not close the transaction. It also sets a protocol-error flag that stays set until reset.

Top module: `coh_serializer`

## Requirements
- R1: After reset `reqReady`, `snpValid`, `cplReady`, `busy` and `protoErr` are all zero.
- R2: At most one `reqReady` bit is high in any cycle, and only while `busy` is low. A request is taken at the clock edge where `reqValid[i]` and `reqReady[i]` are both high, and `busy` is high from the next cycle on.
- R3: Grants rotate. The search starts at the index just after the last granted one, wraps from N-1 to 0, and starts at index 0 after reset.
- R4: In the cycle after a request is taken, `snpValid` has every bit set except the requester's bit.
- R5: `reqOp` value 0 means read and gives `snpInval`=0; value 1 means ownership and gives `snpInval`=1. `snpRequester` holds the requester's index.
- R6: Each `snpValid[k]` stays high until the cycle in which `snpReady[k]` is high, and it is low from the next cycle on. The other bits are unaffected.
- R7: While a transaction is open, no new request is granted. `cplReady` rises only in the cycle after every snoop has been accepted.
- R8: A completion (`cplValid` high while `cplReady` is high) whose `cplIdx` is not the requester leaves the transaction open and sets `protoErr`. `protoErr` then stays high until reset.
- R9: A completion whose `cplIdx` matches the requester lowers `busy` and `cplReady` in the next cycle. A request can be granted in that same cycle.
- R10: The snoop kind and `snpRequester` do not change for the whole transaction, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | N | Initial request present, one bit per controller |
| reqOp | input | N | Request opcode per controller (0 read, 1 ownership) |
| reqReady | output | N | One-hot grant of the request |
| snpValid | output | N | Snoop pending, one bit per destination |
| snpReady | input | N | Destination accepts its snoop |
| snpInval | output | 1 | Snoop kind: 0 share, 1 invalidate |
| snpRequester | output | IDW | Index of the requester, for routing answers |
| cplValid | input | 1 | Completion message present |
| cplIdx | input | IDW | Index of the controller sending the completion |
| cplReady | output | 1 | Block is waiting for the completion |
| busy | output | 1 | A transaction is open |
| protoErr | output | 1 | Sticky flag for a completion from the wrong controller |

## Verification
The hardest situation to reach is a rogue completion. It needs a transaction that has finished its snoop phase and is waiting, plus a completion message from a controller that is not the requester. The stimulus opens a transaction, lets every snoop be accepted, and then sends one completion with another index. It then checks that the transaction is still open and the flag is set, and only after that closes the transaction properly. Staggered snoop acceptance, one destination per cycle, is used to show that per-destination valids are held and that the waiting phase cannot start early.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SNOOP = 2'd1,
    ST_WAIT  = 2'd2
  } cohState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic snoopPhase;
  } cohStrobe_t;

endpackage

// File: rtl/coh_arbiter.sv
module coh_arbiter #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic [N-1:0]   reqValid,
  output logic [N-1:0]   reqReady,
  output logic           gntAny,
  output logic [IDW-1:0] gntIdx
);

  logic [IDW-1:0] ptr;

  always_comb begin
    gntAny = 1'b0;
    gntIdx = '0;
    for (int k = 0; k < N; k++) begin
      int cand;
      cand = int'(ptr) + k;
      if (cand >= N) cand = cand - N;
      if (!gntAny && reqValid[cand]) begin
        gntAny = 1'b1;
        gntIdx = IDW'(cand);
      end
    end
  end

  always_comb begin
    reqReady = '0;
    if (enable && gntAny) reqReady[gntIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (enable && gntAny)
      ptr <= (int'(gntIdx) == N - 1) ? '0 : IDW'(int'(gntIdx) + 1);
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady));

endmodule

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  cohStrobe_t     stb,
  input  logic [IDW-1:0] gntIdx,
  input  logic [N-1:0]   reqOp,
  input  logic [N-1:0]   snpReady,
  output logic [N-1:0]   snpValid,
  output logic           snpInval,
  output logic [IDW-1:0] reqIdxQ,
  output logic           pendDone
);

  logic [N-1:0] pend;
  logic         opQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= '0;
      opQ     <= 1'b0;
      reqIdxQ <= '0;
    end else if (stb.capture) begin
      pend          <= '1;
      pend[gntIdx]  <= 1'b0;
      opQ           <= reqOp[gntIdx];
      reqIdxQ       <= gntIdx;
    end else if (stb.snoopPhase) begin
      pend <= pend & ~snpReady;
    end
  end

  assign snpValid = pend;
  assign snpInval = opQ;
  assign pendDone = ((pend & ~snpReady) == '0);

  // R6
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((snpValid & ~snpReady) != '0) |=>
      ((snpValid & $past(snpValid & ~snpReady)) == $past(snpValid & ~snpReady)));

  // R4
  no_self_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpValid[reqIdxQ] == 1'b0);

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           gntAny,
  input  logic           pendDone,
  input  logic           cplValid,
  input  logic [IDW-1:0] cplIdx,
  input  logic [IDW-1:0] reqIdxQ,
  output cohStrobe_t     stb,
  output logic           arbEnable,
  output logic           cplReady,
  output logic           busy,
  output logic           protoErr
);

  cohState_t state, stateNext;
  logic      cplGood, cplBad;

  assign cplGood = (state == ST_WAIT) && cplValid && (cplIdx == reqIdxQ);
  assign cplBad  = (state == ST_WAIT) && cplValid && (cplIdx != reqIdxQ);

  always_comb begin
    stateNext      = state;
    stb.capture    = 1'b0;
    stb.snoopPhase = 1'b0;
    unique case (state)
      ST_IDLE: begin
        stb.capture = gntAny;
        if (gntAny) stateNext = ST_SNOOP;
      end
      ST_SNOOP: begin
        stb.snoopPhase = 1'b1;
        if (pendDone) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (cplGood) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      protoErr <= 1'b0;
    end else begin
      state <= stateNext;
      if (cplBad) protoErr <= 1'b1;
    end
  end

  assign arbEnable = (state == ST_IDLE);
  assign cplReady  = (state == ST_WAIT);
  assign busy      = (state != ST_IDLE);

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R8
  bad_cpl_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplBad |=> (busy && protoErr));

  // R9
  good_cpl_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplGood |=> !busy);

endmodule

// File: rtl/coh_serializer.sv
module coh_serializer
  import coh_pkg::*;
#(
  parameter int N   = 4,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   reqValid,
  input  logic [N-1:0]   reqOp,
  output logic [N-1:0]   reqReady,
  output logic [N-1:0]   snpValid,
  input  logic [N-1:0]   snpReady,
  output logic           snpInval,
  output logic [IDW-1:0] snpRequester,
  input  logic           cplValid,
  input  logic [IDW-1:0] cplIdx,
  output logic           cplReady,
  output logic           busy,
  output logic           protoErr
);

  cohStrobe_t     stb;
  logic           arbEnable, gntAny, pendDone;
  logic [IDW-1:0] gntIdx, reqIdxQ;

  coh_arbiter #(.N(N), .IDW(IDW)) uArb (
    .clk(clk), .rstN(rstN), .enable(arbEnable), .reqValid(reqValid),
    .reqReady(reqReady), .gntAny(gntAny), .gntIdx(gntIdx)
  );

  coh_ctrl #(.IDW(IDW)) uCtrl (
    .clk(clk), .rstN(rstN), .gntAny(gntAny), .pendDone(pendDone),
    .cplValid(cplValid), .cplIdx(cplIdx), .reqIdxQ(reqIdxQ), .stb(stb),
    .arbEnable(arbEnable), .cplReady(cplReady), .busy(busy), .protoErr(protoErr)
  );

  coh_datapath #(.N(N), .IDW(IDW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .gntIdx(gntIdx), .reqOp(reqOp),
    .snpReady(snpReady), .snpValid(snpValid), .snpInval(snpInval),
    .reqIdxQ(reqIdxQ), .pendDone(pendDone)
  );

  assign snpRequester = reqIdxQ;

  // R2
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady != '0) |-> !busy);

  // R7
  wait_after_snoops_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplReady |-> (snpValid == '0));

  // R10
  stable_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(snpInval) && $stable(snpRequester)));

endmodule

// File: tb/coh_serializer_test.sv
module coh_serializer_test;
  localparam int N = 4;
  localparam int IDW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] reqValid = '0, reqOp = '0, snpReady = '0;
  logic cplValid = 1'b0;
  logic [IDW-1:0] cplIdx = '0;
  logic [N-1:0] reqReady, snpValid;
  logic snpInval, cplReady, busy, protoErr;
  logic [IDW-1:0] snpRequester;

  int vectors = 0, miscompares = 0;
  int expPtr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  coh_serializer #(.N(N)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqReady(reqReady), .snpValid(snpValid), .snpReady(snpReady),
    .snpInval(snpInval), .snpRequester(snpRequester), .cplValid(cplValid),
    .cplIdx(cplIdx), .cplReady(cplReady), .busy(busy), .protoErr(protoErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] others(input int idx);
    logic [N-1:0] m;
    m = '1;
    m[idx] = 1'b0;
    return m;
  endfunction

  task automatic issue(input int idx, input bit op);
    reqValid = '0; reqValid[idx] = 1'b1; reqOp[idx] = op;
    #1;
    check(reqReady == N'(1 << idx), "R2", reqReady, 1 << idx);
    check(idx == expPtr || reqReady != 0, "R3", idx, expPtr);
    @(negedge clk);
    reqValid = '0;
    expPtr = (idx + 1) % N;
    #1;
    check(busy == 1'b1, "R2", busy, 1);
    check(snpValid == others(idx), "R4", snpValid, others(idx));
    check(snpInval == op, "R5", snpInval, op);
    check(snpRequester == IDW'(idx), "R5", snpRequester, idx);
  endtask

  task automatic drain();
    snpReady = '1;
    @(negedge clk);
    snpReady = '0;
    #1;
    check(snpValid == '0, "R6", snpValid, 0);
    check(cplReady == 1'b1, "R7", cplReady, 1);
  endtask

  task automatic complete(input int idx);
    cplValid = 1'b1; cplIdx = IDW'(idx);
    @(negedge clk);
    cplValid = 1'b0;
    #1;
    check(busy == 1'b0, "R9", busy, 0);
    check(cplReady == 1'b0, "R9", cplReady, 0);
  endtask

  task automatic t_reset();
    #1;
    check(reqReady == '0 && snpValid == '0, "R1", {reqReady, snpValid}, 0);
    check(!cplReady && !busy && !protoErr, "R1", {cplReady, busy, protoErr}, 0);
  endtask

  task automatic t_read();
    issue(1, 1'b0);
    reqValid[3] = 1'b1;
    #1;
    check(reqReady == '0, "R7", reqReady, 0);
    drain();
    check(reqReady == '0, "R7", reqReady, 0);
    complete(1);
    check(reqReady == 4'b1000, "R9", reqReady, 4'b1000);
    reqValid = '0;
  endtask

  task automatic t_own();
    issue(2, 1'b1);
    snpReady = 4'b0001;
    @(negedge clk);
    snpReady = '0;
    #1;
    check(snpValid == 4'b1010, "R6", snpValid, 4'b1010);
    check(cplReady == 1'b0, "R7", cplReady, 0);
    @(negedge clk);
    #1;
    check(snpValid == 4'b1010, "R6", snpValid, 4'b1010);
    snpReady = 4'b1000;
    @(negedge clk);
    snpReady = '0;
    #1;
    check(snpValid == 4'b0010, "R6", snpValid, 4'b0010);
    check(cplReady == 1'b0, "R7", cplReady, 0);
    drain();
    complete(2);
  endtask

  task automatic t_wrongCpl();
    issue(3, 1'b0);
    drain();
    cplValid = 1'b1; cplIdx = 2'd1;
    @(negedge clk);
    cplValid = 1'b0;
    #1;
    check(busy == 1'b1 && cplReady == 1'b1, "R8", {busy, cplReady}, 2'b11);
    check(protoErr == 1'b1, "R8", protoErr, 1);
    complete(3);
    check(protoErr == 1'b1, "R8", protoErr, 1);
  endtask

  task automatic t_roundRobin();
    for (int t = 0; t < N; t++) begin
      int exp;
      exp = expPtr;
      reqValid = '1; reqOp = '0;
      #1;
      check(reqReady == N'(1 << exp), "R3", reqReady, 1 << exp);
      @(negedge clk);
      reqValid = '0;
      expPtr = (exp + 1) % N;
      drain();
      complete(exp);
    end
  endtask

  task automatic t_stable();
    int exp;
    exp = expPtr;
    issue(exp, 1'b1);
    reqValid = '1; reqOp = '0;
    repeat (2) @(negedge clk);
    #1;
    check(snpInval == 1'b1, "R10", snpInval, 1);
    check(snpRequester == IDW'(exp), "R10", snpRequester, exp);
    check(snpValid == others(exp), "R10", snpValid, others(exp));
    reqValid = '0;
    drain();
    complete(exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_read();
    t_own();
    t_wrongCpl();
    t_roundRobin();
    t_stable();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule